// File: doc/BRIEF.md
# Operand-Specifier Address Decoder

This block decodes the operand-specifier bytes that follow an opcode in a byte-oriented, variable-length instruction stream. Upstream logic pulses `start_i` once it sees an opcode that carries a mode byte. The decoder then takes one byte per cycle in which `byte_vld_i` is high: first the mode byte, then an optional scale-index-base byte, then an optional displacement of one or four bytes, least significant byte first. How many bytes it takes depends on the values of the mode byte and the scale-index-base byte.

When the last byte has arrived, the decoder forms the result from a snapshot of the eight 32-bit general registers on `regs_i`. Register k occupies bits `[32k+31:32k]`, and the registers are numbered 0 to 7 in the order accumulator, counter, data, base, stack pointer, frame pointer, source index, destination index. The result is either a register operand or a 32-bit effective address. It comes with the register-operand field and the number of bytes consumed, all valid during a one-cycle `done_o` strobe.

Top module: `opspec_decoder`

## Requirements
- R1: After a synchronous reset, `done_o`, `is_reg_o`, `ea_o` and `nbytes_o` are all zero.
- R2: The mode byte is read as mode bits [7:6], register field bits [5:3] and r/m bits [2:0]. `reg_fld_o` always reports bits [5:3], in every mode.
- R3: Mode 11 names a register operand. `is_reg_o`=1, `rm_reg_o` = bits [2:0], `ea_o`=0, `nbytes_o`=1, and no further byte is consumed.
- R4: Mode 00 with r/m other than 100 and 101 gives `ea_o` = register[r/m] and `nbytes_o`=1.
- R5: Mode 01 takes one displacement byte, sign-extends it, adds it to register[r/m] (r/m not 100), and gives `nbytes_o`=2.
- R6: Mode 10 takes four displacement bytes, least significant first, adds them to register[r/m] (r/m not 100), and gives `nbytes_o`=5.
- R7: Mode 00 with r/m 101 takes four displacement bytes as an absolute address, with no base register, and gives `nbytes_o`=5.
- R8: r/m 100 in modes 00, 01 and 10 means a scale-index-base byte follows. Its scale is bits [7:6] (00, 01, 10, 11 give ×1, ×2, ×4, ×8), its index is bits [5:3] and its base is bits [2:0]. `ea_o` = index×scale + base + displacement, and the displacement size follows the mode as in R5 and R6.
- R9: An index field of 100 in the scale-index-base byte means there is no index term, whatever the scale.
- R10: A base field of 101 with mode 00 means there is no base term and a four-byte displacement follows, giving `nbytes_o`=6. With mode 01 or 10, base 101 is an ordinary base register.
- R11: `done_o` is high for exactly one cycle, in the second cycle after the clock edge that accepts the last byte. The decoder is then idle.
- R12: A `start_i` pulse during a decode is ignored. A `byte_vld_i` while idle is ignored and consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin decoding; taken only when idle |
| byte_vld_i | input | 1 | `byte_i` carries a specifier byte this cycle |
| byte_i | input | 8 | Specifier byte |
| regs_i | input | 256 | Register snapshot, register k at bits [32k+31:32k] |
| done_o | output | 1 | One-cycle result strobe |
| is_reg_o | output | 1 | Operand is a register (mode 11) |
| rm_reg_o | output | 3 | r/m register number for a register operand |
| reg_fld_o | output | 3 | Register field of the mode byte |
| ea_o | output | 32 | Effective address (zero for a register operand) |
| nbytes_o | output | 3 | Specifier bytes consumed (1 to 6) |

## Verification
On every cycle, the assertions check the following. The result strobe lasts a single cycle. It appears only after the internal sequencer has reached its compute step. The reset state holds. A register operand always reports a zero address and a one-byte length, and every reported length lies between one and six. The exact address arithmetic can only be shown by the bench's directed scenarios. That covers the scaling, the missing-index and missing-base escapes, the sign extension and the little-endian byte order. The same holds for the strobe latency relative to the last byte and for the ignored start and stray bytes.

// File: rtl/opspec_pkg.sv
package opspec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MODE,
    ST_SIB,
    ST_DISP,
    ST_CALC
  } seq_st_t;

  // mode byte: bits [7:6] mode, [5:3] register field, [2:0] r/m
  typedef struct packed {
    logic [1:0] md;
    logic [2:0] rg;
    logic [2:0] rm;
  } mode_t;

  // scale-index-base byte: [7:6] scale, [5:3] index, [2:0] base
  typedef struct packed {
    logic [1:0] sc;
    logic [2:0] ix;
    logic [2:0] bs;
  } sib_t;

  localparam logic [1:0] MD_NODISP = 2'b00;
  localparam logic [1:0] MD_DISP8  = 2'b01;
  localparam logic [1:0] MD_DISP32 = 2'b10;
  localparam logic [1:0] MD_REG    = 2'b11;
  localparam logic [2:0] RM_ESC    = 3'b100;
  localparam logic [2:0] RM_ABS    = 3'b101;
  localparam logic [2:0] IX_NONE   = 3'b100;

  // number of displacement bytes for a mode; abs_sel marks the no-base escape
  function automatic logic [2:0] disp_bytes(input logic [1:0] md, input logic abs_sel);
    logic [2:0] n;
    case (md)
      MD_DISP8:  n = 3'd1;
      MD_DISP32: n = 3'd4;
      MD_NODISP: n = abs_sel ? 3'd4 : 3'd0;
      default:   n = 3'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/opspec_seq.sv
module opspec_seq
  import opspec_pkg::*;
#(
  parameter int DISP_NB = 4,
  localparam int DIDX_W = $clog2(DISP_NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              vld_i,
  input  logic [7:0]        byte_i,
  output mode_t             mode_o,
  output sib_t              sib_o,
  output logic              has_sib_o,
  output logic [2:0]        dlen_o,
  output logic              clr_o,
  output logic              dwe_o,
  output logic [DIDX_W-1:0] didx_o,
  output logic [2:0]        nbytes_o,
  output logic              calc_o
);

  seq_st_t           st_q;
  mode_t             mode_q;
  sib_t              sib_q;
  logic              has_sib_q;
  logic [2:0]        dlen_q;
  logic [DIDX_W-1:0] dcnt_q;
  logic [2:0]        nb_q;

  mode_t      mode_in;
  sib_t       sib_in;
  logic [2:0] len_mode;
  logic [2:0] len_sib;
  logic       last_disp;

  assign mode_in  = mode_t'(byte_i);
  assign sib_in   = sib_t'(byte_i);
  assign len_mode = disp_bytes(mode_in.md, mode_in.rm == RM_ABS);
  assign len_sib  = disp_bytes(mode_q.md, sib_in.bs == RM_ABS);
  assign last_disp = ({1'b0, dcnt_q} == (dlen_q - 3'd1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      mode_q    <= '0;
      sib_q     <= '0;
      has_sib_q <= 1'b0;
      dlen_q    <= '0;
      dcnt_q    <= '0;
      nb_q      <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q      <= ST_MODE;
            nb_q      <= '0;
            dcnt_q    <= '0;
            has_sib_q <= 1'b0;
            dlen_q    <= '0;
            sib_q     <= '0;
          end
        end
        ST_MODE: begin
          if (vld_i) begin
            mode_q <= mode_in;
            nb_q   <= 3'd1;
            if (mode_in.md == MD_REG) begin
              dlen_q <= '0;
              st_q   <= ST_CALC;
            end else if (mode_in.rm == RM_ESC) begin
              has_sib_q <= 1'b1;
              st_q      <= ST_SIB;
            end else begin
              dlen_q <= len_mode;
              st_q   <= (len_mode == 3'd0) ? ST_CALC : ST_DISP;
            end
          end
        end
        ST_SIB: begin
          if (vld_i) begin
            sib_q  <= sib_in;
            nb_q   <= nb_q + 3'd1;
            dlen_q <= len_sib;
            st_q   <= (len_sib == 3'd0) ? ST_CALC : ST_DISP;
          end
        end
        ST_DISP: begin
          if (vld_i) begin
            nb_q   <= nb_q + 3'd1;
            dcnt_q <= dcnt_q + 1'b1;
            if (last_disp) st_q <= ST_CALC;
          end
        end
        ST_CALC: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mode_o    = mode_q;
  assign sib_o     = sib_q;
  assign has_sib_o = has_sib_q;
  assign dlen_o    = dlen_q;
  assign clr_o     = (st_q == ST_IDLE) && start_i;
  assign dwe_o     = (st_q == ST_DISP) && vld_i;
  assign didx_o    = dcnt_q;
  assign nbytes_o  = nb_q;
  assign calc_o    = (st_q == ST_CALC);

endmodule

// File: rtl/opspec_disp.sv
module opspec_disp #(
  parameter int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int IDX_W  = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        byte_i,
  input  logic [2:0]        len_i,
  output logic [DATA_W-1:0] disp_o
);

  logic [DATA_W-1:0] raw_q;

  // one byte lane per displacement byte, filled least significant first
  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clr_i) begin
        raw_q[g*8 +: 8] <= 8'h00;
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        raw_q[g*8 +: 8] <= byte_i;
      end
    end
  end

  always_comb begin
    case (len_i)
      3'd0:    disp_o = '0;
      3'd1:    disp_o = {{(DATA_W-8){raw_q[7]}}, raw_q[7:0]};
      default: disp_o = raw_q;
    endcase
  end

endmodule

// File: rtl/opspec_agen.sv
module opspec_agen
  import opspec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 8
) (
  input  mode_t             mode_i,
  input  sib_t              sib_i,
  input  logic              has_sib_i,
  input  logic [DATA_W-1:0] disp_i,
  input  logic [DATA_W-1:0] regs_i [NREG],
  output logic [DATA_W-1:0] ea_o
);

  logic [2:0]        base_sel;
  logic              base_off;
  logic              idx_on;
  logic [DATA_W-1:0] base_val;
  logic [DATA_W-1:0] idx_val;

  always_comb begin
    if (has_sib_i) begin
      base_sel = sib_i.bs;
      base_off = (mode_i.md == MD_NODISP) && (sib_i.bs == RM_ABS);
      idx_on   = (sib_i.ix != IX_NONE);
    end else begin
      base_sel = mode_i.rm;
      base_off = (mode_i.md == MD_NODISP) && (mode_i.rm == RM_ABS);
      idx_on   = 1'b0;
    end
    base_val = base_off ? '0 : regs_i[base_sel];
    idx_val  = idx_on ? (regs_i[sib_i.ix] << sib_i.sc) : '0;
    ea_o     = base_val + idx_val + disp_i;
  end

endmodule

// File: rtl/opspec_decoder.sv
module opspec_decoder
  import opspec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  localparam int DISP_NB = DATA_W / 8,
  localparam int DIDX_W  = $clog2(DISP_NB)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic                   byte_vld_i,
  input  logic [7:0]             byte_i,
  input  logic [NREG*DATA_W-1:0] regs_i,
  output logic                   done_o,
  output logic                   is_reg_o,
  output logic [2:0]             rm_reg_o,
  output logic [2:0]             reg_fld_o,
  output logic [DATA_W-1:0]      ea_o,
  output logic [2:0]             nbytes_o
);

  mode_t             seq_mode;
  sib_t              seq_sib;
  logic              seq_has_sib;
  logic [2:0]        seq_dlen;
  logic              seq_clr;
  logic              seq_dwe;
  logic [DIDX_W-1:0] seq_didx;
  logic [2:0]        seq_nbytes;
  logic              seq_calc;
  logic [DATA_W-1:0] disp_w;
  logic [DATA_W-1:0] ea_w;
  logic [DATA_W-1:0] reg_arr [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_unpack
    assign reg_arr[k] = regs_i[k*DATA_W +: DATA_W];
  end

  opspec_seq #(.DISP_NB(DISP_NB)) i_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .vld_i    (byte_vld_i),
    .byte_i   (byte_i),
    .mode_o   (seq_mode),
    .sib_o    (seq_sib),
    .has_sib_o(seq_has_sib),
    .dlen_o   (seq_dlen),
    .clr_o    (seq_clr),
    .dwe_o    (seq_dwe),
    .didx_o   (seq_didx),
    .nbytes_o (seq_nbytes),
    .calc_o   (seq_calc)
  );

  opspec_disp #(.DATA_W(DATA_W)) i_disp (
    .clk   (clk),
    .rst   (rst),
    .clr_i (seq_clr),
    .we_i  (seq_dwe),
    .idx_i (seq_didx),
    .byte_i(byte_i),
    .len_i (seq_dlen),
    .disp_o(disp_w)
  );

  opspec_agen #(.DATA_W(DATA_W), .NREG(NREG)) i_agen (
    .mode_i   (seq_mode),
    .sib_i    (seq_sib),
    .has_sib_i(seq_has_sib),
    .disp_i   (disp_w),
    .regs_i   (reg_arr),
    .ea_o     (ea_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      is_reg_o  <= 1'b0;
      rm_reg_o  <= '0;
      reg_fld_o <= '0;
      ea_o      <= '0;
      nbytes_o  <= '0;
    end else begin
      done_o <= seq_calc;
      if (seq_calc) begin
        is_reg_o  <= (seq_mode.md == MD_REG);
        rm_reg_o  <= seq_mode.rm;
        reg_fld_o <= seq_mode.rg;
        ea_o      <= (seq_mode.md == MD_REG) ? '0 : ea_w;
        nbytes_o  <= seq_nbytes;
      end
    end
  end

endmodule

// File: rtl/opspec_decoder_chk.sv
module opspec_decoder_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              is_reg,
  input logic [DATA_W-1:0] ea,
  input logic [2:0]        nbytes,
  input logic              calc
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !done);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  done_after_calc_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(calc));

  // R3
  reg_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (done && is_reg) |-> (ea == '0 && nbytes == 3'd1));

  // R10
  length_range_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (nbytes >= 3'd1 && nbytes <= 3'd6));

endmodule

bind opspec_decoder opspec_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .done  (done_o),
  .is_reg(is_reg_o),
  .ea    (ea_o),
  .nbytes(nbytes_o),
  .calc  (seq_calc)
);

// File: tb/test_opspec_decoder.sv
module test_opspec_decoder;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         byte_vld_i = 1'b0;
  logic [7:0]   byte_i = 8'h00;
  logic [255:0] regs_i;
  logic         done_o;
  logic         is_reg_o;
  logic [2:0]   rm_reg_o;
  logic [2:0]   reg_fld_o;
  logic [31:0]  ea_o;
  logic [2:0]   nbytes_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  opspec_decoder i_opspec_decoder (
    .clk(clk), .rst(rst), .start_i(start_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .regs_i(regs_i), .done_o(done_o), .is_reg_o(is_reg_o),
    .rm_reg_o(rm_reg_o), .reg_fld_o(reg_fld_o), .ea_o(ea_o), .nbytes_o(nbytes_o)
  );

  function automatic logic [31:0] regv(input int k);
    return 32'h0000_1000 * (k + 1) + k;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drives start, then n bytes (byte 0 in the lowest lane), checks the strobe window
  task automatic run_op(input logic [47:0] bytes, input int n, input logic x_reg,
                        input logic [2:0] x_rm, input logic [2:0] x_fld,
                        input logic [31:0] x_ea, input logic [2:0] x_n,
                        input string tag);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_vld_i = 1'b1;
      byte_i = bytes[i*8 +: 8];
      @(negedge clk);
    end
    byte_vld_i = 1'b0;
    chk(done_o == 1'b0, {tag, " R11 early"}, 32'(done_o), 32'd0);
    @(negedge clk);
    chk(done_o == 1'b1, {tag, " R11 strobe"}, 32'(done_o), 32'd1);
    chk(is_reg_o == x_reg, {tag, " is_reg"}, 32'(is_reg_o), 32'(x_reg));
    chk(reg_fld_o == x_fld, {tag, " R2 reg field"}, 32'(reg_fld_o), 32'(x_fld));
    chk(ea_o == x_ea, {tag, " ea"}, ea_o, x_ea);
    chk(nbytes_o == x_n, {tag, " nbytes"}, 32'(nbytes_o), 32'(x_n));
    if (x_reg) chk(rm_reg_o == x_rm, {tag, " rm reg"}, 32'(rm_reg_o), 32'(x_rm));
    @(negedge clk);
    chk(done_o == 1'b0, {tag, " R11 one cycle"}, 32'(done_o), 32'd0);
  endtask

  task automatic t_reset();
    chk(done_o == 1'b0 && is_reg_o == 1'b0, "R1 flags", {30'd0, done_o, is_reg_o}, 32'd0);
    chk(ea_o == 32'd0 && nbytes_o == 3'd0, "R1 ea/len", ea_o, 32'd0);
  endtask

  task automatic t_regmode();
    // 11 010 011 -> register operand 3, field 2 (R3)
    run_op(48'hD3, 1, 1'b1, 3'd3, 3'd2, 32'd0, 3'd1, "R3 reg mode");
  endtask

  task automatic t_nodisp();
    // 00 001 110 -> [reg6] (R4)
    run_op(48'h0E, 1, 1'b0, 3'd0, 3'd1, regv(6), 3'd1, "R4 indirect");
  endtask

  task automatic t_disp8();
    // 01 000 001, disp -16 (R5 negative)
    run_op(48'hF0_41, 2, 1'b0, 3'd0, 3'd0, regv(1) - 32'd16, 3'd2, "R5 disp8 neg");
    // 01 000 111, disp +127 (R5 positive)
    run_op(48'h7F_47, 2, 1'b0, 3'd0, 3'd0, regv(7) + 32'd127, 3'd2, "R5 disp8 pos");
  endtask

  task automatic t_disp32();
    // 10 111 011, disp 0x12345678 (R6)
    run_op(48'h12345678_BB, 5, 1'b0, 3'd0, 3'd7, regv(3) + 32'h12345678, 3'd5, "R6 disp32");
  endtask

  task automatic t_direct();
    // 00 100 101 -> absolute 0xDEADBEEF (R7)
    run_op(48'hDEADBEEF_25, 5, 1'b0, 3'd0, 3'd4, 32'hDEADBEEF, 3'd5, "R7 direct");
  endtask

  task automatic t_sib();
    // 00 000 100 + 10 001 011: reg1*4 + reg3 (R8)
    run_op(48'h8B_04, 2, 1'b0, 3'd0, 3'd0, regv(1) * 4 + regv(3), 3'd2, "R8 sib x4");
    // 01 000 100 + 11 110 101 + disp -128: reg6*8 + reg5 - 128 (R8, R10 base 101 kept)
    run_op(48'h80_F5_44, 3, 1'b0, 3'd0, 3'd0, regv(6) * 8 + regv(5) - 32'd128, 3'd3,
           "R8 R10 sib x8 disp8");
    // 00 000 100 + 00 100 100: stack-pointer base only (R8, R9)
    run_op(48'h24_04, 2, 1'b0, 3'd0, 3'd0, regv(4), 3'd2, "R9 sib sp base");
  endtask

  task automatic t_noindex();
    // 10 000 100 + 11 100 000 + disp 1: index 100 dropped despite scale (R9)
    run_op(48'h00000001_E0_84, 6, 1'b0, 3'd0, 3'd0, regv(0) + 32'd1, 3'd6, "R9 no index");
  endtask

  task automatic t_nobase();
    // 00 000 100 + 01 010 101 + disp 0x1000: reg2*2 + disp (R10)
    run_op(48'h00001000_55_04, 6, 1'b0, 3'd0, 3'd0, regv(2) * 2 + 32'h1000, 3'd6,
           "R10 no base");
  endtask

  task automatic t_ignore();
    // stray bytes while idle: no strobe (R12)
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) byte_vld_i = 1'b1; byte_i = 8'hC0;
    end
    @(negedge clk) byte_vld_i = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, "R12 idle bytes", 32'(done_o), 32'd0);
    // start inside a decode: 01 011 010 then extra start, then disp 0x05 (R12)
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0; byte_vld_i = 1'b1; byte_i = 8'h5A;
    @(negedge clk) byte_vld_i = 1'b0; start_i = 1'b1;
    @(negedge clk) start_i = 1'b0; byte_vld_i = 1'b1; byte_i = 8'h05;
    @(negedge clk) byte_vld_i = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b1, "R12 start ignored strobe", 32'(done_o), 32'd1);
    chk(ea_o == regv(2) + 32'd5, "R12 start ignored ea", ea_o, regv(2) + 32'd5);
    chk(nbytes_o == 3'd2, "R12 start ignored len", 32'(nbytes_o), 32'd2);
    chk(reg_fld_o == 3'd3, "R12 R2 field", 32'(reg_fld_o), 32'd3);
    @(negedge clk);
    @(negedge clk);
    chk(done_o == 1'b0, "R12 no second strobe", 32'(done_o), 32'd0);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) regs_i[k*32 +: 32] = regv(k);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmode();
    t_nodisp();
    t_disp8();
    t_disp32();
    t_direct();
    t_sib();
    t_noindex();
    t_nobase();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule